// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core stops running its normal program and enters debug mode. It has three ways in. One is a vector of debug event requests, each gated by its own bit in an enable register. One is a forced request from the development port, which no mask can block. The last is a request sampled at reset, which puts the core in debug mode from the first cycle after reset with no normal instruction run first.

On entry the block stores the address of the interrupted instruction and the problem-state (user) bit. It forces privileged state and steers instruction fetch to the development port. Load and store traffic is not steered, so data accesses still reach system memory. A sticky cause register records every qualifying request, including those that arrive while the core is already in debug mode. The OR of its bits goes out to the port, so new pending events stay visible. A return command hands the saved address and privilege bit back to the pipeline, and normal fetch resumes on the next cycle.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset with `dbg_on_rst_i` low, `dbg_mode_o`, `fetch_port_o`, `cause_or_o` and both readable registers are 0, and `pr_o` follows `pr_i`.
- R2: An event whose enable bit is clear causes no entry and sets no cause bit.
- R3: An event whose enable bit is set makes `dbg_mode_o` high from the cycle after it is sampled and sets cause bit i (bit i = event i). Several enabled events in one cycle set all their bits and cause a single entry.
- R4: `force_i` enters debug mode on the next clock, whatever the enable register holds, and sets cause bit 6.
- R5: If `dbg_on_rst_i` is high while reset is released, `dbg_mode_o` and `fetch_port_o` are high from release. The first clock edge sets cause bit 7 and saves `pc_i` as the resume address.
- R6: On entry the block saves the `pc_i` and `pr_i` of the entry cycle and presents them on `resume_pc_o` and `resume_pr_o`.
- R7: While in debug mode, `fetch_port_o` is 1 and `pr_o` is 0.
- R8: `cause_or_o` is the OR of the cause bits. It goes high one cycle after a qualifying request, in debug mode as well.
- R9: While in debug mode, further events and force requests set cause bits but do not change the saved resume address.
- R10: Writing with `reg_sel_i`=1 clears each cause bit written as 1. A bit being set in the same cycle stays set.
- R11: `ret_i` in debug mode raises `resume_o` in that cycle. From the next cycle `dbg_mode_o` and `fetch_port_o` are 0, and `resume_pr_o` still holds the saved bit.
- R12: `reg_sel_i`=0 selects the enable register (bits 5:0, bits 7:6 read 0, written by `reg_we_i`). `reg_sel_i`=1 selects the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_on_rst_i | input | 1 | Debug-on-reset request, sampled at reset release |
| evt_i | input | 6 | Debug event requests |
| force_i | input | 1 | Forced entry from development port |
| ret_i | input | 1 | Return-from-debug command |
| pc_i | input | 32 | Address of the instruction about to execute |
| pr_i | input | 1 | Current problem-state bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 cause |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register contents |
| dbg_mode_o | output | 1 | Core is in debug mode |
| fetch_port_o | output | 1 | Instruction fetch served by development port |
| pr_o | output | 1 | Effective problem-state bit |
| cause_or_o | output | 1 | OR of all cause bits |
| resume_o | output | 1 | Return accepted this cycle |
| resume_pc_o | output | 32 | Saved resume address |
| resume_pr_o | output | 1 | Saved problem-state bit |

## Verification
The hardest cases to reach come up only once the core is already in debug mode. These are a second event or force request that must not move the resume address, and a clear that lands in the same cycle as a new event. The bench first enters through one source and clears the cause register. It then drives a fresh event with a different `pc_i`, and finally writes all-ones to the cause register while the same event is still held. Debug-on-reset is reached by holding `dbg_on_rst_i` high through reset release and the first edge.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_CAUSE  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dbg_cause_regs.sv
module dbg_cause_regs
  import dbg_entry_pkg::*;
#(
  parameter int unsigned EVT_W = 6,
  localparam int unsigned CW = EVT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             force_i,
  input  logic             boot_entry_i,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [CW-1:0]    wdata_i,
  output logic [EVT_W-1:0] en_o,
  output logic [CW-1:0]    cause_o,
  output logic             hit_o
);
  logic [EVT_W-1:0] en_q;
  logic [CW-1:0]    cause_q, set_vec, clr_vec;
  logic [EVT_W-1:0] qual;

  assign qual    = evt_i & en_q;
  assign set_vec = {boot_entry_i, force_i, qual};
  assign clr_vec = (we_i && sel_i == SEL_CAUSE) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      cause_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_ENABLE) en_q <= wdata_i[EVT_W-1:0];
      // set has priority over W1C clear
      cause_q <= (cause_q & ~clr_vec) | set_vec;
    end
  end

  assign en_o    = en_q;
  assign cause_o = cause_q;
  assign hit_o   = |qual;

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == SEL_CAUSE) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  a_r3_cause_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> ((cause_q[EVT_W-1:0] & $past(qual)) == $past(qual)));

  a_r2_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) && !(we_i && sel_i == SEL_CAUSE) |=> cause_q[EVT_W-1:0] == $past(cause_q[EVT_W-1:0]));
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              force_i,
  input  logic              dbg_on_rst_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              pr_i,
  output logic              dbg_mode_o,
  output logic              boot_entry_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] resume_pc_o,
  output logic              resume_pr_o,
  output logic              pr_o
);
  logic              dbg_q, boot_q, saved_pr_q;
  logic [ADDR_W-1:0] saved_pc_q;
  logic              boot_req, enter_go;

  // first cycle after reset: debug-on-reset takes effect before any edge
  assign boot_req = boot_q & dbg_on_rst_i;
  assign enter_go = !dbg_q & (hit_i | force_i | boot_req);
  assign resume_o = dbg_q & ret_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q      <= 1'b0;
      boot_q     <= 1'b1;
      saved_pc_q <= '0;
      saved_pr_q <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      if (resume_o) begin
        dbg_q <= 1'b0;
      end else if (enter_go) begin
        dbg_q      <= 1'b1;
        saved_pc_q <= pc_i;
        saved_pr_q <= pr_i;
      end
    end
  end

  assign dbg_mode_o   = dbg_q | boot_req;
  assign boot_entry_o = boot_req;
  assign resume_pc_o  = saved_pc_q;
  assign resume_pr_o  = saved_pr_q;
  assign pr_o         = dbg_mode_o ? 1'b0 : pr_i;

  a_r4_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_q && force_i |=> dbg_q);

  a_r6_save_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_q) |-> resume_pc_o == $past(pc_i));

  a_r9_no_reentry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_q && !ret_i |=> dbg_q && $stable(resume_pc_o));

  a_r11_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_q && ret_i |=> !dbg_q && $stable(resume_pr_o));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int unsigned EVT_W  = 6,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned CW = EVT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_on_rst_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              force_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              pr_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [CW-1:0]     reg_wdata_i,
  output logic [CW-1:0]     reg_rdata_o,
  output logic              dbg_mode_o,
  output logic              fetch_port_o,
  output logic              pr_o,
  output logic              cause_or_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] resume_pc_o,
  output logic              resume_pr_o
);
  logic [EVT_W-1:0] en;
  logic [CW-1:0]    cause;
  logic             hit, boot_entry, dbg_mode;

  dbg_cause_regs #(.EVT_W(EVT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_i),
    .force_i      (force_i),
    .boot_entry_i (boot_entry),
    .we_i         (reg_we_i),
    .sel_i        (reg_sel_i),
    .wdata_i      (reg_wdata_i),
    .en_o         (en),
    .cause_o      (cause),
    .hit_o        (hit)
  );

  dbg_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .force_i      (force_i),
    .dbg_on_rst_i (dbg_on_rst_i),
    .ret_i        (ret_i),
    .pc_i         (pc_i),
    .pr_i         (pr_i),
    .dbg_mode_o   (dbg_mode),
    .boot_entry_o (boot_entry),
    .resume_o     (resume_o),
    .resume_pc_o  (resume_pc_o),
    .resume_pr_o  (resume_pr_o),
    .pr_o         (pr_o)
  );

  assign dbg_mode_o   = dbg_mode;
  // only instruction fetch is redirected; data accesses are untouched
  assign fetch_port_o = dbg_mode;
  assign cause_or_o   = |cause;
  assign reg_rdata_o  = (reg_sel_i == SEL_CAUSE) ? cause : {2'b00, en};

  a_r8_cause_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{boot_entry, force_i, hit}) |=> cause_or_o);
endmodule

// File: tb/tb_dbg_entry_ctrl.sv
module tb_dbg_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbg_on_rst = 1'b0;
  logic [5:0]  evt = '0;
  logic        force_r = 1'b0, ret = 1'b0, pr = 1'b0;
  logic [31:0] pc = '0;
  logic        we = 1'b0, sel = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        dbg_mode, fetch_port, pr_out, cause_or, resume;
  logic [31:0] resume_pc;
  logic        resume_pr;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dbg_entry_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_on_rst_i(dbg_on_rst), .evt_i(evt),
    .force_i(force_r), .ret_i(ret), .pc_i(pc), .pr_i(pr),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dbg_mode_o(dbg_mode), .fetch_port_o(fetch_port), .pr_o(pr_out),
    .cause_or_o(cause_or), .resume_o(resume), .resume_pc_o(resume_pc),
    .resume_pr_o(resume_pr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    we = 1'b1; sel = s; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    sel = s; #1; d = rdata;
  endtask

  task automatic do_reset(input logic req);
    @(negedge clk);
    rst_ni = 1'b0; dbg_on_rst = req;
    tick(); tick();
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    pr = 1'b1;
    do_reset(1'b0);
    chk("R1 dbg_mode", dbg_mode, 0);
    chk("R1 fetch", fetch_port, 0);
    chk("R1 cause_or", cause_or, 0);
    chk("R1 pr follows", pr_out, 1);
    rd(1'b0, d); chk("R1 enable", d, 0);
    rd(1'b1, d); chk("R1 cause", d, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1'b0, 8'h00);
    evt = 6'h04; tick(); evt = '0;
    chk("R2 no entry", dbg_mode, 0);
    rd(1'b1, d); chk("R2 no cause", d, 0);
  endtask

  task automatic t_enabled_entry();
    logic [7:0] d;
    wr(1'b0, 8'hFF);
    rd(1'b0, d); chk("R12 enable readback", d, 8'h3F);
    pc = 32'h0000_0100; pr = 1'b1; evt = 6'h21;
    tick(); evt = '0; pc = 32'h0000_0104;
    chk("R3 entered", dbg_mode, 1);
    rd(1'b1, d); chk("R3 multi cause", d, 8'h21);
    chk("R7 fetch port", fetch_port, 1);
    chk("R7 privileged", pr_out, 0);
    chk("R8 cause_or", cause_or, 1);
    chk("R6 resume pc", resume_pc, 32'h100);
    chk("R6 resume pr", resume_pr, 1);
  endtask

  task automatic t_in_debug();
    logic [7:0] d;
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R10 cleared", d, 0);
    chk("R8 cause_or low", cause_or, 0);
    pc = 32'h0000_0200; evt = 6'h02; tick();
    chk("R9 pc kept", resume_pc, 32'h100);
    chk("R8 cause_or in debug", cause_or, 1);
    rd(1'b1, d); chk("R9 cause set", d, 8'h02);
    // clear and set in the same cycle: set wins
    we = 1'b1; sel = 1'b1; wdata = 8'hFF; tick(); we = 1'b0; evt = '0;
    rd(1'b1, d); chk("R10 set wins", d, 8'h02);
    force_r = 1'b1; tick(); force_r = 1'b0;
    chk("R9 force in debug pc kept", resume_pc, 32'h100);
    wr(1'b1, 8'hFF);
  endtask

  task automatic t_return();
    ret = 1'b1; pr = 1'b0; #1;
    chk("R11 resume pulse", resume, 1);
    tick(); ret = 1'b0;
    chk("R11 left debug", dbg_mode, 0);
    chk("R11 fetch memory", fetch_port, 0);
    chk("R11 resume pr kept", resume_pr, 1);
    chk("R11 pr follows", pr_out, 0);
    chk("R11 no resume", resume, 0);
  endtask

  task automatic t_force();
    logic [7:0] d;
    wr(1'b0, 8'h00);
    pc = 32'h0000_0300; pr = 1'b1; force_r = 1'b1;
    tick(); force_r = 1'b0;
    chk("R4 forced entry", dbg_mode, 1);
    chk("R4 resume pc", resume_pc, 32'h300);
    rd(1'b1, d); chk("R4 cause bit6", d, 8'h40);
    ret = 1'b1; tick(); ret = 1'b0;
    chk("R4 returned", dbg_mode, 0);
  endtask

  task automatic t_boot();
    logic [7:0] d;
    pc = 32'h0000_0400;
    do_reset(1'b1);
    chk("R5 debug at release", dbg_mode, 1);
    chk("R5 fetch at release", fetch_port, 1);
    @(negedge clk);
    tick(); dbg_on_rst = 1'b0;
    rd(1'b1, d); chk("R5 cause bit7", d, 8'h80);
    chk("R5 still debug", dbg_mode, 1);
    chk("R5 resume pc", resume_pc, 32'h400);
    ret = 1'b1; tick(); ret = 1'b0;
    chk("R5 returned", dbg_mode, 0);
  endtask

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_mask();
    t_enabled_entry();
    t_in_debug();
    t_return();
    t_force();
    t_boot();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule